// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit keeps four segment origin registers, one each for the code, input, output and workspace areas of a 4096-word memory of 32-bit words. Each register is a single 32-bit word. The upper 14 bits hold the base byte address of the segment and the lower 18 bits hold its length in bytes. A translate request names a segment and gives a byte displacement. One clock later the unit returns the byte address, the word index and a fault code. The fault code says whether the displacement ran past the segment length, or whether a full-word access landed off a word boundary.

Software or a loader fills the registers through a write port. A plain write stores the whole word. The code segment always starts at byte 0, so its base field is forced to zero. A chained write takes only the length from the data. It places the segment at the first byte after the segment in the register below it. Loading the four lengths in order therefore packs the segments end to end. Workspace initialisation uses an ordinary translation against the workspace register, with a displacement of four times the word offset.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, every origin register is zero and `rsp_valid`, `rsp_ok` and `rsp_fault` are 0. A translation before any load therefore faults with code 7.
- R2: A plain write (`wr_auto`=0) stores `wr_data` in the register chosen by `wr_idx`, with the base in bits 31:18 and the length in bits 17:0. For register 0 the stored base is always 0.
- R3: A chained write (`wr_auto`=1) to register k>0 stores the length from `wr_data[17:0]`. It sets the base to the base of register k-1 plus the low 14 bits of that register's length, modulo 16384. A chained write to register 0 gives base 0.
- R4: A request raises `rsp_valid` for exactly the next cycle. `rsp_addr` = base + displacement, modulo 16384, and is reported whether or not a fault occurs.
- R5: `rsp_word_idx` equals `rsp_addr` shifted right by 2.
- R6: A displacement greater than or equal to the segment length gives fault code 7. A zero-length segment therefore always faults.
- R7: When `req_word`=1 and the two low bits of the byte address are not both zero, the fault code is 3. A byte access (`req_word`=0) is never checked for alignment.
- R8: When both the limit and the alignment conditions hold, the code is 7.
- R9: On success the fault code is 0 and `rsp_ok`=1. `rsp_ok` is 0 whenever the code is nonzero.
- R10: Only the two low bits of `req_sel` choose the register; the higher bits have no effect.
- R11: A request in the same cycle as a write to the same register translates with the register contents from before that write.
- R12: In the cycle after a clock edge with no request, `rsp_valid` and `rsp_ok` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Origin register write strobe |
| wr_auto | input | 1 | Chained write: place the segment after the previous one |
| wr_idx | input | 2 | Register to write (0 code, 1 input, 2 output, 3 workspace) |
| wr_data | input | 32 | Register word: base in 31:18, length in 17:0 |
| req_valid | input | 1 | Translate request strobe |
| req_sel | input | SEL_W (3) | Segment selector; low two bits used |
| req_disp | input | DISP_W (12) | Byte displacement into the segment |
| req_word | input | 1 | Access is a full word (alignment checked) |
| rsp_valid | output | 1 | Result present this cycle |
| rsp_ok | output | 1 | Result has no fault |
| rsp_fault | output | 4 | 0 none, 3 alignment, 7 segment limit |
| rsp_addr | output | 14 | Byte address |
| rsp_word_idx | output | 12 | Word index |

## Verification
A register write and a translation can land on the same edge, and they can target the same register. The bench provokes this case by raising both strobes in one cycle. The write sets the workspace-style register's length to zero and moves its base. The result must still show the old base and no fault. A second request one cycle later must show the new base with fault 7. The limit and alignment checks also meet in one request, where a misaligned word access is also out of range. That case is judged by requiring code 7.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    localparam int NUM_SEG = 4;
    localparam int SEG_IDX_W = $clog2(NUM_SEG);
    localparam int BASE_W = 14;
    localparam int LEN_W = 18;
    localparam int FAULT_W = 4;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [LEN_W-1:0]  len;
    } origin_t;

    typedef enum logic [FAULT_W-1:0] {
        FLT_NONE  = 4'd0,
        FLT_ALIGN = 4'd3,
        FLT_LIMIT = 4'd7
    } fault_e;
endpackage

// File: rtl/seg_origin_bank.sv
module seg_origin_bank
    import seg_xlate_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          wr_auto,
    input  logic [SEG_IDX_W-1:0]          wr_idx,
    input  logic [31:0]                   wr_data,
    output origin_t [NUM_SEG-1:0]         org_o
);
    origin_t [NUM_SEG-1:0] org_d, org_q;
    origin_t                prev_seg;
    origin_t                wr_word;

    always_comb begin
        org_d    = org_q;
        prev_seg = org_q[wr_idx - SEG_IDX_W'(1)];
        wr_word  = origin_t'(wr_data);
        if (wr_auto) begin
            wr_word.base = (wr_idx == '0) ? '0
                         : BASE_W'(prev_seg.base + BASE_W'(prev_seg.len));
        end
        if (wr_idx == '0) begin
            wr_word.base = '0;
        end
        if (wr_en) begin
            org_d[wr_idx] = wr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) org_q <= '0;
        else        org_q <= org_d;
    end

    assign org_o = org_q;

    assert_code_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == '0) |=> (org_q[0].base == '0));

    assert_chain_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_auto && wr_idx != '0) |=>
        (org_q[$past(wr_idx)].base ==
         $past(BASE_W'(org_q[wr_idx - SEG_IDX_W'(1)].base
                     + BASE_W'(org_q[wr_idx - SEG_IDX_W'(1)].len)))));
endmodule

// File: rtl/seg_fault_check.sv
module seg_fault_check
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DISP_W = 12
) (
    input  origin_t              org,
    input  logic [DISP_W-1:0]    disp,
    input  logic                 word_acc,
    output logic [ADDR_W-1:0]    addr,
    output logic [FAULT_W-1:0]   fault
);
    logic over_limit;
    logic misaligned;

    always_comb begin
        addr       = ADDR_W'(org.base) + ADDR_W'(disp);
        over_limit = (LEN_W'(disp) >= org.len);
        misaligned = word_acc && (addr[1:0] != 2'b00);
        if (over_limit)      fault = FLT_LIMIT;
        else if (misaligned) fault = FLT_ALIGN;
        else                 fault = FLT_NONE;
    end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int MEM_WORDS = 4096,
    parameter int DISP_W    = 12,
    parameter int SEL_W     = 3,
    localparam int ADDR_W   = $clog2(MEM_WORDS) + 2,
    localparam int WORD_W   = ADDR_W - 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_auto,
    input  logic [SEG_IDX_W-1:0]  wr_idx,
    input  logic [31:0]           wr_data,
    input  logic                  req_valid,
    input  logic [SEL_W-1:0]      req_sel,
    input  logic [DISP_W-1:0]     req_disp,
    input  logic                  req_word,
    output logic                  rsp_valid,
    output logic                  rsp_ok,
    output logic [FAULT_W-1:0]    rsp_fault,
    output logic [ADDR_W-1:0]     rsp_addr,
    output logic [WORD_W-1:0]     rsp_word_idx
);
    typedef struct packed {
        logic               valid;
        logic               ok;
        logic [FAULT_W-1:0] fault;
        logic [ADDR_W-1:0]  addr;
    } rsp_t;

    origin_t [NUM_SEG-1:0] org;
    origin_t               sel_org;
    logic [SEG_IDX_W-1:0]  seg_idx;
    logic [ADDR_W-1:0]     xl_addr;
    logic [FAULT_W-1:0]    xl_fault;
    rsp_t                  rsp_d, rsp_q;

    seg_origin_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_auto (wr_auto),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .org_o   (org)
    );

    assign seg_idx = req_sel[SEG_IDX_W-1:0];

    generate
        if (SEL_W > SEG_IDX_W) begin : g_sel_hi
            logic sel_hi_unused;
            assign sel_hi_unused = ^req_sel[SEL_W-1:SEG_IDX_W];
        end
    endgenerate

    assign sel_org = org[seg_idx];

    seg_fault_check #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_check (
        .org      (sel_org),
        .disp     (req_disp),
        .word_acc (req_word),
        .addr     (xl_addr),
        .fault    (xl_fault)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = 1'b0;
        rsp_d.ok    = 1'b0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.ok    = (xl_fault == FLT_NONE);
            rsp_d.fault = xl_fault;
            rsp_d.addr  = xl_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid    = rsp_q.valid;
    assign rsp_ok       = rsp_q.ok;
    assign rsp_fault    = rsp_q.fault;
    assign rsp_addr     = rsp_q.addr;
    assign rsp_word_idx = rsp_q.addr[ADDR_W-1:2];

    assert_limit_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (LEN_W'(req_disp) >= sel_org.len)) |=>
        (rsp_fault == 4'd7 && !rsp_ok));

    assert_word_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ok && $past(req_word)) |-> (rsp_addr[1:0] == 2'b00));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_ok));
endmodule

// File: tb/sim_seg_xlate_unit.sv
module sim_seg_xlate_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_auto = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_sel = '0;
    logic [11:0] req_disp = '0;
    logic        req_word = 1'b0;
    logic        rsp_valid, rsp_ok;
    logic [3:0]  rsp_fault;
    logic [13:0] rsp_addr;
    logic [11:0] rsp_word_idx;

    int n_tests = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    seg_xlate_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_auto(wr_auto),
        .wr_idx(wr_idx), .wr_data(wr_data), .req_valid(req_valid),
        .req_sel(req_sel), .req_disp(req_disp), .req_word(req_word),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_fault(rsp_fault),
        .rsp_addr(rsp_addr), .rsp_word_idx(rsp_word_idx)
    );

    // {sel, disp, word, expected addr, expected fault}
    localparam int NV = 12;
    localparam logic [33:0] VEC [NV] = '{
        {3'd0, 12'h008, 1'b1, 14'h0008, 4'd0},  // R4
        {3'd1, 12'h004, 1'b1, 14'h0044, 4'd0},  // R4
        {3'd2, 12'h00B, 1'b0, 14'h005B, 4'd0},  // R7 byte access
        {3'd2, 12'h00C, 1'b1, 14'h005C, 4'd7},  // R6
        {3'd3, 12'h006, 1'b1, 14'h0062, 4'd3},  // R7
        {3'd3, 12'h006, 1'b0, 14'h0062, 4'd0},  // R7 byte access
        {3'd3, 12'h021, 1'b1, 14'h007D, 4'd7},  // R8
        {3'd5, 12'h008, 1'b1, 14'h0048, 4'd0},  // R10
        {3'd7, 12'h01C, 1'b1, 14'h0078, 4'd0},  // R10
        {3'd0, 12'h03F, 1'b0, 14'h003F, 4'd0},  // R6 last byte
        {3'd0, 12'h040, 1'b0, 14'h0040, 4'd7},  // R6 first byte out
        {3'd1, 12'h00F, 1'b1, 14'h004F, 4'd3}   // R7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] idx, input logic autom, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_auto = autom; wr_idx = idx; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_auto = 1'b0;
    endtask

    task automatic translate(input logic [2:0] sel, input logic [11:0] disp, input logic word);
        @(negedge clk);
        req_valid = 1'b1; req_sel = sel; req_disp = disp; req_word = word;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic check_rsp(input string req, input logic [13:0] ea, input logic [3:0] ef);
        check({req, " valid"}, 32'(rsp_valid), 32'd1);
        check({req, " addr"}, 32'(rsp_addr), 32'(ea));
        check({req, " R5 word index"}, 32'(rsp_word_idx), 32'(ea >> 2));
        check({req, " fault"}, 32'(rsp_fault), 32'(ef));
        check({req, " R9 ok"}, 32'(rsp_ok), 32'(ef == 4'd0));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", 32'(rsp_valid), 32'd0);
        check("R1 ok", 32'(rsp_ok), 32'd0);
        check("R1 fault", 32'(rsp_fault), 32'd0);
        rst_n = 1'b1;
        translate(3'd0, 12'h000, 1'b1);
        check_rsp("R1 empty segment", 14'h0000, 4'd7);

        // R3 chained loads: lengths 0x40, 0x10, 0x0C, 0x20
        write_reg(2'd0, 1'b1, {14'h0003, 18'h00040});
        write_reg(2'd1, 1'b1, {14'h0111, 18'h00010});
        write_reg(2'd2, 1'b1, 32'h0000_000C);
        write_reg(2'd3, 1'b1, 32'h0000_0020);
        translate(3'd3, 12'h000, 1'b1);
        check_rsp("R3 chained base", 14'h005C, 4'd0);

        for (int i = 0; i < NV; i++) begin
            translate(VEC[i][33:31], VEC[i][30:19], VEC[i][18]);
            check_rsp($sformatf("R4 vector %0d", i), VEC[i][17:4], VEC[i][3:0]);
        end

        // R12 idle cycle
        @(negedge clk);
        check("R12 valid idle", 32'(rsp_valid), 32'd0);
        check("R12 ok idle", 32'(rsp_ok), 32'd0);

        // R2 plain write, register 0 base forced to zero
        write_reg(2'd0, 1'b0, {14'h3FFF, 18'h00100});
        translate(3'd0, 12'h080, 1'b1);
        check_rsp("R2 code base zero", 14'h0080, 4'd0);
        write_reg(2'd2, 1'b0, {14'h1000, 18'h00010});
        translate(3'd2, 12'h004, 1'b1);
        check_rsp("R2 plain write", 14'h1004, 4'd0);

        // R11 simultaneous write and translate to register 1
        @(negedge clk);
        wr_en = 1'b1; wr_auto = 1'b0; wr_idx = 2'd1; wr_data = {14'h0200, 18'h0};
        req_valid = 1'b1; req_sel = 3'd1; req_disp = 12'h004; req_word = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check_rsp("R11 old contents", 14'h0044, 4'd0);
        translate(3'd1, 12'h004, 1'b1);
        check_rsp("R11 new contents", 14'h0204, 4'd7);

        // R3 and R4 wrap modulo 16384
        write_reg(2'd2, 1'b0, {14'h3FF0, 18'h00020});
        write_reg(2'd3, 1'b1, 32'h0000_0040);
        translate(3'd3, 12'h000, 1'b1);
        check_rsp("R3 base wrap", 14'h0010, 4'd0);
        translate(3'd2, 12'h01C, 1'b1);
        check_rsp("R4 address wrap", 14'h000C, 4'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule